// File: doc/BRIEF.md
# Inbound Interrupt Message Write Forwarder

This block sits between two downstream request ports and one upstream transaction port. Each downstream port offers memory writes carrying an address, a data word and, on the second port, a flag that marks the request as having PCI ordering semantics. A write is taken into a shared posting buffer of eight entries when there is room. When there is no room, the write is answered with a retry and the requester must offer it again later. The buffer's state does not change on a retry.

Writes leave the buffer in the order they were posted. Only at that point are they sorted by address. A write whose upper twelve address bits equal 0xFEE is sent upstream as an interrupt message. Every other write, and any write from the second port that lacks PCI semantics, goes upstream as an ordinary memory write. At the input, interrupt writes get no special path and no priority. Because sorting happens after posting, an interrupt message can never overtake an earlier posted write.

Top module: `iwf_forwarder`

## Requirements
- R1: After reset the upstream port shows no valid transaction, and neither downstream port receives an accept or a retry until it presents a request.
- R2: A request presented while the buffer holds fewer than 8 entries is accepted in the same cycle, and the entry is posted at the next rising clock edge.
- R3: While the buffer holds 8 entries, every request is retried, even in a cycle where the head is being taken. The upstream stream is unchanged by a retried request.
- R4: When both ports request in a cycle with room in the buffer, the preferred port is accepted and the other port is retried. Port 0 is preferred after reset. After any accept, the preference moves to the port that was not accepted.
- R5: In each cycle, a port with a valid request receives exactly one of accept and retry. A port with no valid request receives neither. At most one write is posted per cycle.
- R6: A posted write is visible upstream in the cycle after its posting edge. Transactions leave in posting order. The head transaction holds all of its fields while up_valid is high and up_ready is low, and it is removed at the edge where both are high.
- R7: up_kind is 1 (interrupt message) when address bits [31:20] equal 0xFEE and the write came from port 0, or from port 1 with p1_pci high. Otherwise up_kind is 0 (ordinary memory write).
- R8: Each upstream transaction carries the posted address and data unchanged. up_src is 0 for port 0 and 1 for port 1.
- R9: The accept or retry decision does not depend on the request's address, data or PCI flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_valid | input | 1 | Port 0 write request |
| p0_addr | input | 32 | Port 0 write address |
| p0_data | input | 32 | Port 0 write data |
| p0_accept | output | 1 | Port 0 request posted this cycle |
| p0_retry | output | 1 | Port 0 request refused, must be re-presented |
| p1_valid | input | 1 | Port 1 write request |
| p1_addr | input | 32 | Port 1 write address |
| p1_data | input | 32 | Port 1 write data |
| p1_pci | input | 1 | Port 1 request has PCI semantics |
| p1_accept | output | 1 | Port 1 request posted this cycle |
| p1_retry | output | 1 | Port 1 request refused, must be re-presented |
| up_valid | output | 1 | Upstream transaction available |
| up_ready | input | 1 | Upstream side takes the transaction |
| up_kind | output | 1 | 1 interrupt message, 0 ordinary memory write |
| up_addr | output | 32 | Transaction address |
| up_data | output | 32 | Transaction data |
| up_src | output | 1 | Originating port |

## Verification
Accept and retry are combinational responses, so the bench drives each request just after a falling edge and compares the responses one time step later, in that same cycle. A posted write becomes the upstream head one rising edge later. The bench therefore keeps a reference queue that takes the pop before the push at each edge, and at every falling edge it compares the upstream port against the front of that queue. The sweeps cover address windows, both ports, the PCI flag, contention, full-buffer stalls and random back-pressure. Every request that is retried is offered again until it is accepted, so a lost or duplicated write shows up as a mismatch between the two streams.

// File: rtl/iwf_pkg.sv
package iwf_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WIN_W  = 12;
    localparam logic [WIN_W-1:0] IRQ_WINDOW = 12'hFEE;

    typedef enum logic {
        XFER_MEMWR  = 1'b0,
        XFER_IRQMSG = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pci_sem;
        logic              src;
    } post_entry_t;

    typedef struct packed {
        xfer_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              src;
    } up_xfer_t;

    function automatic logic hits_irq_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: WIN_W] == IRQ_WINDOW;
    endfunction

    function automatic xfer_kind_e classify(input post_entry_t e);
        if (hits_irq_window(e.addr) && e.pci_sem)
            return XFER_IRQMSG;
        return XFER_MEMWR;
    endfunction

endpackage

// File: rtl/iwf_rr_arb.sv
module iwf_rr_arb #(
    parameter int N_REQ = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_REQ-1:0]         req,
    input  logic                     space_ok,
    output logic [N_REQ-1:0]         grant,
    output logic [N_REQ-1:0]         retry,
    output logic [$clog2(N_REQ)-1:0] grant_idx
);
    localparam int IDX_W = $clog2(N_REQ);

    logic [IDX_W-1:0] prio_q;
    logic             found;

    always_comb begin
        found     = 1'b0;
        grant_idx = prio_q;
        for (int off = 0; off < N_REQ; off++) begin
            int cand;
            cand = (int'(prio_q) + off) % N_REQ;
            if (!found && req[cand]) begin
                found     = 1'b1;
                grant_idx = IDX_W'(cand);
            end
        end
    end

    always_comb begin
        grant = '0;
        if (found && space_ok)
            grant[grant_idx] = 1'b1;
        retry = req & ~grant;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prio_q <= '0;
        else if (found && space_ok)
            prio_q <= IDX_W'((int'(grant_idx) + 1) % N_REQ);
    end

    // R4
    prio_move_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (prio_q != $past(grant_idx)));

    // R3
    no_room_chk: assert property (@(posedge clk) disable iff (rst)
        (!space_ok) |-> (grant == '0));

endmodule

// File: rtl/iwf_post_fifo.sv
module iwf_post_fifo #(
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  iwf_pkg::post_entry_t  push_entry,
    input  logic                  pop,
    output iwf_pkg::post_entry_t  head,
    output logic                  not_empty,
    output logic                  full
);
    import iwf_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    post_entry_t      store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (count != '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign head      = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> not_empty);

    // R3
    full_push_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

endmodule

// File: rtl/iwf_classify.sv
module iwf_classify (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  iwf_pkg::post_entry_t entry,
    output iwf_pkg::up_xfer_t    xfer
);
    import iwf_pkg::*;

    always_comb begin
        xfer.kind = classify(entry);
        xfer.addr = entry.addr;
        xfer.data = entry.data;
        xfer.src  = entry.src;
    end

    // R7
    irq_window_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && xfer.kind == XFER_IRQMSG) |-> (xfer.addr[ADDR_W-1 -: WIN_W] == IRQ_WINDOW));

endmodule

// File: rtl/iwf_forwarder.sv
module iwf_forwarder #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        p0_valid,
    input  logic [31:0] p0_addr,
    input  logic [31:0] p0_data,
    output logic        p0_accept,
    output logic        p0_retry,
    input  logic        p1_valid,
    input  logic [31:0] p1_addr,
    input  logic [31:0] p1_data,
    input  logic        p1_pci,
    output logic        p1_accept,
    output logic        p1_retry,
    output logic        up_valid,
    input  logic        up_ready,
    output logic        up_kind,
    output logic [31:0] up_addr,
    output logic [31:0] up_data,
    output logic        up_src
);
    import iwf_pkg::*;

    localparam int N_PORTS = 2;
    localparam int IDX_W   = $clog2(N_PORTS);

    post_entry_t        port_entry [N_PORTS];
    logic [N_PORTS-1:0] req_vec, grant_vec, retry_vec;
    logic [IDX_W-1:0]   grant_idx;
    logic               buf_full, buf_nempty, do_push, do_pop;
    post_entry_t        head_entry;
    up_xfer_t           head_xfer;

    assign req_vec = {p1_valid, p0_valid};

    always_comb begin
        port_entry[0] = '{addr: p0_addr, data: p0_data, pci_sem: 1'b1, src: 1'b0};
        port_entry[1] = '{addr: p1_addr, data: p1_data, pci_sem: p1_pci, src: 1'b1};
    end

    iwf_rr_arb #(.N_REQ(N_PORTS)) arb_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req_vec),
        .space_ok  (!buf_full),
        .grant     (grant_vec),
        .retry     (retry_vec),
        .grant_idx (grant_idx)
    );

    assign do_push = |grant_vec;
    assign do_pop  = buf_nempty && up_ready;

    iwf_post_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .push       (do_push),
        .push_entry (port_entry[grant_idx]),
        .pop        (do_pop),
        .head       (head_entry),
        .not_empty  (buf_nempty),
        .full       (buf_full)
    );

    iwf_classify cls_i (
        .clk   (clk),
        .rst   (rst),
        .valid (buf_nempty),
        .entry (head_entry),
        .xfer  (head_xfer)
    );

    assign p0_accept = grant_vec[0];
    assign p1_accept = grant_vec[1];
    assign p0_retry  = retry_vec[0];
    assign p1_retry  = retry_vec[1];

    assign up_valid = buf_nempty;
    assign up_kind  = head_xfer.kind;
    assign up_addr  = head_xfer.addr;
    assign up_data  = head_xfer.data;
    assign up_src   = head_xfer.src;

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
            // R5
            resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
                req_vec[p] |-> (grant_vec[p] ^ retry_vec[p]));
            // R5
            resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !req_vec[p] |-> !(grant_vec[p] || retry_vec[p]));
        end
    endgenerate

    // R5
    single_post_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({p1_accept, p0_accept}) <= 1);

    // R3
    full_retry_chk: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !(p0_accept || p1_accept));

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_ready) |=> (up_valid && $stable(up_addr) && $stable(up_data)
                                     && $stable(up_kind) && $stable(up_src)));

endmodule

// File: tb/iwf_forwarder_tb.sv
module iwf_forwarder_tb_top;
    import iwf_pkg::*;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        p0_valid, p1_valid, p1_pci, up_ready;
    logic [31:0] p0_addr, p0_data, p1_addr, p1_data;
    logic        p0_accept, p0_retry, p1_accept, p1_retry;
    logic        up_valid, up_kind, up_src;
    logic [31:0] up_addr, up_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    iwf_forwarder #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .p0_valid(p0_valid), .p0_addr(p0_addr), .p0_data(p0_data),
        .p0_accept(p0_accept), .p0_retry(p0_retry),
        .p1_valid(p1_valid), .p1_addr(p1_addr), .p1_data(p1_data), .p1_pci(p1_pci),
        .p1_accept(p1_accept), .p1_retry(p1_retry),
        .up_valid(up_valid), .up_ready(up_ready), .up_kind(up_kind),
        .up_addr(up_addr), .up_data(up_data), .up_src(up_src)
    );

    up_xfer_t model_q[$];
    logic     exp_prio;
    int       posted_total, drained_total;

    logic        pend_v [2];
    logic [31:0] pend_a [2];
    logic [31:0] pend_d [2];
    logic        pend_p;
    logic        got_acc [2];
    int          seq_no;
    logic [31:0] lfsr;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_kind(input logic [31:0] a, input logic src, input logic pci);
        return (a[31:20] == 12'hFEE) && (src == 1'b0 || pci);
    endfunction

    task automatic step(input logic rdy);
        logic exp_a0, exp_a1, g;
        up_xfer_t nx;
        @(negedge clk);
        p0_valid = pend_v[0]; p0_addr = pend_a[0]; p0_data = pend_d[0];
        p1_valid = pend_v[1]; p1_addr = pend_a[1]; p1_data = pend_d[1]; p1_pci = pend_p;
        up_ready = rdy;
        #1;
        exp_a0 = 1'b0; exp_a1 = 1'b0; g = 1'b0;
        if (model_q.size() < DEPTH) begin
            if (pend_v[0] && pend_v[1]) begin g = exp_prio; exp_a0 = !g; exp_a1 = g; end
            else if (pend_v[0]) begin g = 1'b0; exp_a0 = 1'b1; end
            else if (pend_v[1]) begin g = 1'b1; exp_a1 = 1'b1; end
        end
        // R2 R3 R4 R9: accept/retry from occupancy and preference only
        check("R4", "p0_accept", 64'(p0_accept), 64'(exp_a0));
        check("R4", "p1_accept", 64'(p1_accept), 64'(exp_a1));
        // R5: exactly one response per valid request
        check("R5", "p0_retry", 64'(p0_retry), 64'(pend_v[0] && !exp_a0));
        check("R5", "p1_retry", 64'(p1_retry), 64'(pend_v[1] && !exp_a1));
        // R6: head visible and in order
        check("R6", "up_valid", 64'(up_valid), 64'(model_q.size() != 0));
        if (model_q.size() != 0) begin
            check("R7", "up_kind", 64'(up_kind), 64'(model_q[0].kind));
            check("R8", "up_addr", 64'(up_addr), 64'(model_q[0].addr));
            check("R8", "up_data", 64'(up_data), 64'(model_q[0].data));
            check("R8", "up_src",  64'(up_src),  64'(model_q[0].src));
        end
        got_acc[0] = exp_a0; got_acc[1] = exp_a1;
        if (rdy && model_q.size() != 0) begin
            void'(model_q.pop_front());
            drained_total++;
        end
        if (exp_a0 || exp_a1) begin
            nx.kind = xfer_kind_e'(exp_kind(pend_a[g], g, g ? pend_p : 1'b1));
            nx.addr = pend_a[g];
            nx.data = pend_d[g];
            nx.src  = g;
            model_q.push_back(nx);
            posted_total++;
            exp_prio = !g;
        end
    endtask

    function automatic logic [31:0] next_lfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic new_req(input int p, input logic [31:0] a);
        pend_v[p] = 1'b1;
        pend_a[p] = a;
        seq_no++;
        pend_d[p] = 32'hD000_0000 + 32'(seq_no);
    endtask

    task automatic drain_all();
        pend_v[0] = 1'b0; pend_v[1] = 1'b0;
        for (int i = 0; i < 3 * DEPTH && model_q.size() != 0; i++) step(1'b1);
        step(1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [11:0] wins [6];
        wins[0] = 12'hFEE; wins[1] = 12'hFED; wins[2] = 12'hFEF;
        wins[3] = 12'h000; wins[4] = 12'hFFE; wins[5] = 12'h7EE;
        seq_no = 0; posted_total = 0; drained_total = 0;
        exp_prio = 1'b0; lfsr = 32'h1234_5679;
        pend_v[0] = 1'b0; pend_v[1] = 1'b0; pend_p = 1'b0;
        pend_a[0] = '0; pend_a[1] = '0; pend_d[0] = '0; pend_d[1] = '0;
        p0_valid = 0; p1_valid = 0; p1_pci = 0; up_ready = 0;
        p0_addr = 0; p0_data = 0; p1_addr = 0; p1_data = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1: reset state
        check("R1", "up_valid after reset", 64'(up_valid), 64'd0);
        check("R1", "p0 responses idle", 64'({p0_accept, p0_retry}), 64'd0);
        check("R1", "p1 responses idle", 64'({p1_accept, p1_retry}), 64'd0);

        // R7 R8 R2: classification sweep over window, port and pci flag
        for (int w = 0; w < 6; w++)
            for (int s = 0; s < 2; s++)
                for (int pci = 0; pci < 2; pci++) begin
                    new_req(s, {wins[w], 20'h0_0A5} + 32'(w * 4));
                    pend_p = pci[0];
                    step(1'b1);
                    pend_v[0] = 1'b0; pend_v[1] = 1'b0;
                    step(1'b1);
                end
        drain_all();

        // R4: sustained contention, both ports keep re-presenting
        new_req(0, 32'h1000_0000); new_req(1, 32'hFEE0_0100); pend_p = 1'b1;
        for (int i = 0; i < 16; i++) begin
            step(1'b1);
            for (int p = 0; p < 2; p++)
                if (got_acc[p]) new_req(p, (p == 0 ? 32'hFEE0_0000 : 32'h2000_0000) + 32'(i));
        end
        drain_all();

        // R3: fill with upstream stalled, then retries while full, pop while full
        new_req(0, 32'hFEE1_2340); new_req(1, 32'h3000_0000); pend_p = 1'b0;
        for (int i = 0; i < 14; i++) begin
            step(1'b0);
            for (int p = 0; p < 2; p++)
                if (got_acc[p]) new_req(p, 32'hFEE0_0000 + 32'(i * 16 + p));
        end
        check("R3", "buffer full depth", 64'(model_q.size()), 64'(DEPTH));
        step(1'b1);   // pop while full: requests still retried
        step(1'b0);   // now room for one
        step(1'b0);
        drain_all();

        // R9 R6: random traffic with random back-pressure
        for (int i = 0; i < 600; i++) begin
            lfsr = next_lfsr(lfsr);
            for (int p = 0; p < 2; p++)
                if (!pend_v[p] && lfsr[p]) begin
                    lfsr = next_lfsr(lfsr);
                    new_req(p, lfsr[4] ? {12'hFEE, lfsr[19:0]} : lfsr);
                end
            pend_p = lfsr[7];
            step(lfsr[9] | lfsr[10]);
            for (int p = 0; p < 2; p++)
                if (got_acc[p]) pend_v[p] = 1'b0;
        end
        drain_all();
        // R6: nothing lost or duplicated
        check("R6", "posted equals drained", 64'(posted_total), 64'(drained_total));
        check("R6", "up_valid idle at end", 64'(up_valid), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule